// File: doc/BRIEF.md
# Iterative Binary-to-BCD Converter

This block turns an unsigned binary word of parameterised width into packed decimal digits, four bits per digit, using the shift-and-add-3 technique. One correction-and-shift step runs per clock, so a conversion of a `BIN_W`-bit word takes `BIN_W` cycles. It needs only a handful of 4-bit comparators and adders and no divider or lookup table.

A one-cycle `start` while the block is idle captures `bin_in` into a working register. That register holds the decimal digit field in its upper part and the operand in its lower `BIN_W` bits. On each step, every digit nibble of 5 or more gets 3 added to it, all digits in the same cycle. The whole register then moves left by one bit. After the last step the digit field is copied to `bcd_out` and `done` pulses for one cycle. A host that needs a decimal readout of a counter or a measurement pulses `start` and waits for `done`.

Top module: `bin2bcd_iter`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `busy`, `done` and `bcd_out` are all zero.
- R2: A `start` sampled high while `busy` is low is accepted, and `busy` is high from the following cycle.
- R3: `done` rises exactly `BIN_W` clock edges after the edge that accepted `start`. `busy` falls on that same edge, so the two are never high together.
- R4: `done` is high for exactly one cycle per conversion.
- R5: When `done` is high, `bcd_out` holds the decimal value of the accepted `bin_in`. Digit k (units are k=0) sits in bits [4k+3:4k], and there are ceil(`BIN_W`/3) digits. With `BIN_W`=16, 243 gives 0x000243, 65244 gives 0x065244 and 65535 gives 0x065535.
- R6: Every 4-bit digit of `bcd_out` is in the range 0 to 9. This holds because of the add-3 correction to digits of 5 or more before each shift.
- R7: `bcd_out` changes only on the edge that raises `done`. Between completions it keeps its last result.
- R8: A `start` sampled while `busy` is high is ignored. The running conversion keeps its timing and its result, and no second `done` follows.
- R9: `bin_in` is sampled only on the accepting edge. Changes to it during a conversion have no effect on the result.
- R10: Asserting `rst` during a conversion aborts it. After release, no `done` appears until a new `start` is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a conversion (taken only when idle) |
| bin_in | input | BIN_W | Unsigned binary operand |
| bcd_out | output | 4*ceil(BIN_W/3) | Packed decimal result, units digit lowest |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse when `bcd_out` is updated |

## Verification
The checker counts the edges on which `busy` is high, so the timing property for R3 assumes `start` is the only way into a run. It also assumes the bench holds `rst` for more than one edge at time zero, so that the hold property never compares against an unreset `bcd_out`. The bench drives `start` and `bin_in` only on falling edges, keeps `start` to one-cycle pulses, and begins with several reset cycles. Stray `start` pulses during a run are sent on purpose, to show that they neither shorten the run nor disturb the counter the checker keeps.

// File: rtl/b2b_pkg.sv
package b2b_pkg;

    // Decimal digits needed to hold any value of an n-bit word.
    function automatic int unsigned digits_for(input int unsigned n);
        return (n + 2) / 3;
    endfunction

    // Add-3 correction for a single decimal digit before it is doubled.
    function automatic logic [3:0] nibble_fix(input logic [3:0] d);
        return (d >= 4'd5) ? d + 4'd3 : d;
    endfunction

    // Per-step control from the sequencer to the datapath.
    typedef struct packed {
        logic load;   // capture operand, clear digit field
        logic step;   // perform one correct-and-shift
        logic last;   // this step is the final one
    } b2b_ctl_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } b2b_state_e;

endpackage

// File: rtl/b2b_adjust.sv
module b2b_adjust
    import b2b_pkg::*;
#(
    parameter int unsigned DIG_N = 6
) (
    input  logic [4*DIG_N-1:0] dig_in,
    output logic [4*DIG_N-1:0] dig_out
);

    genvar g;
    generate
        for (g = 0; g < DIG_N; g++) begin : g_nib
            assign dig_out[4*g +: 4] = nibble_fix(dig_in[4*g +: 4]);
        end
    endgenerate

endmodule

// File: rtl/b2b_seq.sv
module b2b_seq
    import b2b_pkg::*;
#(
    parameter int unsigned BIN_W = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    output b2b_ctl_t ctl,
    output logic     busy
);

    localparam int unsigned CNT_W = (BIN_W < 2) ? 1 : $clog2(BIN_W);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BIN_W - 1);

    b2b_state_e        state_q;
    logic [CNT_W-1:0]  idx_q;

    always_comb begin
        ctl.load = (state_q == ST_IDLE) && start;
        ctl.step = (state_q == ST_RUN);
        ctl.last = (state_q == ST_RUN) && (idx_q == LAST_IDX);
    end

    assign busy = (state_q == ST_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else if (ctl.load) begin
            state_q <= ST_RUN;
            idx_q   <= '0;
        end else if (ctl.step) begin
            idx_q <= idx_q + 1'b1;
            if (ctl.last) begin
                state_q <= ST_IDLE;
            end
        end
    end

endmodule

// File: rtl/b2b_scratch.sv
module b2b_scratch
    import b2b_pkg::*;
#(
    parameter int unsigned BIN_W = 16,
    parameter int unsigned DIG_N = 6
) (
    input  logic                   clk,
    input  logic                   rst,
    input  b2b_ctl_t               ctl,
    input  logic [BIN_W-1:0]       bin_in,
    output logic [4*DIG_N-1:0]     dig_next
);

    localparam int unsigned BCD_W = 4 * DIG_N;
    localparam int unsigned SCR_W = BIN_W + BCD_W;

    logic [SCR_W-1:0] scr_q;
    logic [SCR_W-1:0] scr_fixed;
    logic [SCR_W-1:0] scr_shift;
    logic [BCD_W-1:0] dig_fixed;

    b2b_adjust #(.DIG_N(DIG_N)) u_adjust (
        .dig_in  (scr_q[SCR_W-1 -: BCD_W]),
        .dig_out (dig_fixed)
    );

    assign scr_fixed = {dig_fixed, scr_q[BIN_W-1:0]};
    assign scr_shift = {scr_fixed[SCR_W-2:0], 1'b0};
    assign dig_next  = scr_shift[SCR_W-1 -: BCD_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            scr_q <= '0;
        end else if (ctl.load) begin
            scr_q <= {{BCD_W{1'b0}}, bin_in};
        end else if (ctl.step) begin
            scr_q <= scr_shift;
        end
    end

endmodule

// File: rtl/bin2bcd_iter.sv
module bin2bcd_iter
    import b2b_pkg::*;
#(
    parameter int unsigned BIN_W = 16,
    localparam int unsigned DIG_N = (BIN_W + 2) / 3,
    localparam int unsigned BCD_W = 4 * DIG_N
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [BIN_W-1:0] bin_in,
    output logic [BCD_W-1:0] bcd_out,
    output logic             busy,
    output logic             done
);

    b2b_ctl_t          ctl;
    logic [BCD_W-1:0]  dig_next;

    b2b_seq #(.BIN_W(BIN_W)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .ctl   (ctl),
        .busy  (busy)
    );

    b2b_scratch #(.BIN_W(BIN_W), .DIG_N(DIG_N)) u_scratch (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .bin_in   (bin_in),
        .dig_next (dig_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bcd_out <= '0;
            done    <= 1'b0;
        end else begin
            done <= ctl.step && ctl.last;
            if (ctl.step && ctl.last) begin
                bcd_out <= dig_next;
            end
        end
    end

endmodule

// File: rtl/bin2bcd_iter_chk.sv
module bin2bcd_iter_chk #(
    parameter int unsigned BIN_W = 16,
    parameter int unsigned BCD_W = 24
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [BCD_W-1:0] bcd_out,
    input logic             busy,
    input logic             done
);

    localparam int unsigned CW = $clog2(BIN_W + 2);

    logic [CW-1:0] busy_cnt;

    // Edges seen with busy high since the last accepted start.
    always_ff @(posedge clk) begin
        if (rst) begin
            busy_cnt <= '0;
        end else if (start && !busy) begin
            busy_cnt <= '0;
        end else if (busy) begin
            busy_cnt <= busy_cnt + 1'b1;
        end
    end

    function automatic logic digits_ok(input logic [BCD_W-1:0] v);
        logic ok;
        ok = 1'b1;
        for (int k = 0; k < BCD_W / 4; k++) begin
            if (v[4*k +: 4] > 4'd9) ok = 1'b0;
        end
        return ok;
    endfunction

    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!busy && !done && bcd_out == '0));

    a_r2_accept: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    a_r3_latency: assert property (@(posedge clk) disable iff (rst)
        done |-> (busy_cnt == CW'(BIN_W)));

    a_r3_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(done && busy));

    a_r4_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r6_digits_valid: assert property (@(posedge clk) disable iff (rst)
        done |-> digits_ok(bcd_out));

    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (!done && !$past(rst)) |-> $stable(bcd_out));

endmodule

bind bin2bcd_iter bin2bcd_iter_chk #(.BIN_W(BIN_W), .BCD_W(BCD_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .bcd_out (bcd_out),
    .busy    (busy),
    .done    (done)
);

// File: tb/tb_bin2bcd_iter.sv
module tb_bin2bcd_iter;

    localparam int BIN_W = 16;
    localparam int BCD_W = 24;
    localparam int NVEC  = 16;
    localparam logic [15:0] VEC [NVEC] = '{
        16'd0, 16'd1, 16'd9, 16'd10, 16'd99, 16'd100, 16'd243, 16'd255,
        16'd999, 16'd1000, 16'd4095, 16'd9999, 16'd10000, 16'd12345,
        16'd65244, 16'd65535
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [BIN_W-1:0] bin_in = '0;
    logic [BCD_W-1:0] bcd_out;
    logic             busy;
    logic             done;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    bin2bcd_iter #(.BIN_W(BIN_W)) dut (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .bin_in  (bin_in),
        .bcd_out (bcd_out),
        .busy    (busy),
        .done    (done)
    );

    function automatic logic [BCD_W-1:0] ref_bcd(input int unsigned v);
        logic [BCD_W-1:0] r;
        int unsigned x;
        x = v;
        r = '0;
        for (int k = 0; k < BCD_W / 4; k++) begin
            r[4*k +: 4] = 4'(x % 10);
            x = x / 10;
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Pulse start with value v; optional stray start and operand change mid-run.
    // Returns edges from the accepting edge to done.
    task automatic convert(input logic [BIN_W-1:0] v, input bit disturb, output int lat);
        @(negedge clk);
        bin_in = v;
        start  = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        check("R2 busy after accept", 32'(busy), 32'd1);
        while (!done && lat < BIN_W + 8) begin
            if (disturb && lat == 4) begin
                start  = 1'b1;
                bin_in = ~v;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int lat;
        logic [BCD_W-1:0] held;

        repeat (4) @(negedge clk);
        check("R1 busy in reset", 32'(busy), 32'd0);
        check("R1 done in reset", 32'(done), 32'd0);
        check("R1 bcd_out in reset", 32'(bcd_out), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 idle after release", 32'({busy, done}), 32'd0);

        // Vector table: value and latency (R5, R3, R6).
        for (int i = 0; i < NVEC; i++) begin
            convert(VEC[i], 1'b0, lat);
            check("R3 latency", 32'(lat), 32'(BIN_W + 1));
            check("R3 busy low with done", 32'(busy), 32'd0);
            check("R5 value", 32'(bcd_out), 32'(ref_bcd(int'(VEC[i]))));
            // R4 single pulse, R7 hold
            held = bcd_out;
            @(negedge clk);
            check("R4 done one cycle", 32'(done), 32'd0);
            repeat (3) @(negedge clk);
            check("R7 bcd_out held", 32'(bcd_out), 32'(held));
        end

        // R6 spot check on a value with every digit >= 5 along the way.
        convert(16'd59999, 1'b0, lat);
        check("R6 digits 5..9 carry", 32'(bcd_out), 32'h059999);

        // R8 + R9: stray start and operand change during run.
        convert(16'd243, 1'b1, lat);
        check("R8 latency unchanged", 32'(lat), 32'(BIN_W + 1));
        check("R9 result from accepted operand", 32'(bcd_out), 32'h000243);
        bin_in = 16'd0;
        repeat (BIN_W + 4) begin
            @(negedge clk);
            if (done) check("R8 no second done", 32'(done), 32'd0);
        end
        check("R8 idle after run", 32'(busy), 32'd0);
        check("R7 value kept while idle", 32'(bcd_out), 32'h000243);

        // R10: reset mid-conversion.
        @(negedge clk);
        bin_in = 16'd777;
        start  = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R10 busy cleared", 32'(busy), 32'd0);
        check("R10 bcd_out cleared", 32'(bcd_out), 32'd0);
        repeat (BIN_W + 4) begin
            @(negedge clk);
            if (done) check("R10 no done after abort", 32'(done), 32'd0);
        end
        check("R10 still idle", 32'({busy, done}), 32'd0);

        convert(16'd777, 1'b0, lat);
        check("R5 after abort", 32'(bcd_out), 32'h000777);

        finish_run();
    end

endmodule